// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block brings 48 external input lines into the clock domain through a synchronizer chain and presents their live levels on a small byte-wide register bus with eight offsets. The lines are grouped in eight-line slices. Each slice can be armed so that any level change on any of its lines is caught in a per-slice flag and drives an interrupt request.

Software reads the input levels one byte at a time. When the interrupt line fires, it reads the status byte. A low pending bit means this port is the source, which matters when the interrupt line is shared with other devices. The low six bits name the slices that changed. Reading the status byte clears everything it reported. A change that arrives on the same clock edge as that read is kept for the next read.

The read data is combinational from the address and the registered state. Only a read strobe at the status offset has a side effect. Writes anywhere except the status offset are ignored.

Top module: `cos_input_port`

## Requirements
- R1: Offsets 0, 1 and 2 return the synchronized levels of lines 0-7, 8-15 and 16-23. Line 8k+i appears in bit i of byte k.
- R2: Offsets 4, 5 and 6 return the synchronized levels of lines 24-31, 32-39 and 40-47. The bit order is the same as in R1.
- R3: Offset 3 always reads 0x00, and bit 7 of the status byte at offset 7 always reads 0.
- R4: A write to offset 7 loads bits 0-5 as the arm bits for slices 0-5, where slice g holds lines 8g..8g+7. Writing 0 disarms every slice. After reset all slices are disarmed, and writes to other offsets change nothing.
- R5: A rise or a fall on any line of an armed slice sets that slice's flag, seen as status bit g. A change driven before clock edge n shows on `irq` after edge n+2.
- R6: A change in a disarmed slice sets no flag and is not remembered, so arming the slice afterwards raises nothing.
- R7: Status bit 6 reads 0 while any slice flag is set and 1 when none is set.
- R8: A read of offset 7 returns the flags as they were and clears all of them on that clock edge.
- R9: A change that would set a flag on the same clock edge as a status read is kept, and it appears in the next status read.
- R10: `irq` is high exactly while at least one slice flag is set.
- R11: After reset no flag is set, `irq` is low and the status byte reads 0x40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | Asynchronous input lines |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe; at offset 7 it clears the flags |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the bus strobes and address are stable around each clock edge. They also assume that `rd_en` and `wr_en` are never high together. The bench drives every bus signal and every input line on the falling edge and issues one access per cycle, so it stays inside those limits. Input lines are changed on purpose only. The bench then waits long enough for the synchronizer to settle before it reads status, except in the cases that target latency and the read/change collision.

// File: rtl/cos_port_pkg.sv
package cos_port_pkg;
   localparam int          BUS_W      = 8;
   localparam int          ADDR_W     = 3;
   localparam logic [2:0]  OFS_STATUS = 3'd7;
   localparam logic [2:0]  OFS_GAP    = 3'd3;
   localparam int          PEND_BIT   = 6;

   typedef enum logic [1:0] {
      RD_LEVEL  = 2'd0,
      RD_GAP    = 2'd1,
      RD_STATUS = 2'd2
   } rd_kind_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cos_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cos_group_detect.sv
module cos_group_detect #(
   parameter int GROUP_W    = 8,
   parameter int NUM_GROUPS = 6,
   localparam int LINES     = GROUP_W * NUM_GROUPS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINES-1:0]      lvl,
   input  logic [NUM_GROUPS-1:0] arm,
   input  logic                  clr,
   output logic [NUM_GROUPS-1:0] flags
);
   logic [LINES-1:0]      prev_lvl;
   logic [NUM_GROUPS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= '0;
      else        prev_lvl <= lvl;
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic armed_hit;

      assign hit[g]    = |(lvl[g*GROUP_W +: GROUP_W] ^ prev_lvl[g*GROUP_W +: GROUP_W]);
      assign armed_hit = hit[g] & arm[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[g] <= 1'b0;
         else        flags[g] <= (flags[g] & ~clr) | armed_hit;
      end

      // R6: an unarmed or quiet slice never gains a flag
      p_no_set_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags[g] && !(hit[g] && arm[g])) |=> !flags[g]);
      // R8: a status read with no new change empties the flag
      p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !(hit[g] && arm[g])) |=> !flags[g]);
      // R9: an armed change is never dropped, even during a read
      p_change_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[g] && arm[g]) |=> flags[g]);
      // R5: a flag stays until a read takes it
      p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !clr) |=> flags[g]);
   end
endmodule

// File: rtl/cos_regmap.sv
module cos_regmap
   import cos_port_pkg::*;
#(
   parameter int GROUP_W     = 8,
   parameter int BANK_GROUPS = 3,
   localparam int NUM_GROUPS = 2 * BANK_GROUPS,
   localparam int LINES      = GROUP_W * NUM_GROUPS
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [LINES-1:0]      lvl,
   input  logic [NUM_GROUPS-1:0] flags,
   output logic [BUS_W-1:0]      rdata
);
   if (GROUP_W != BUS_W) begin : g_bad_width
      $error("slice width must equal bus width");
   end
   if (BANK_GROUPS != 3) begin : g_bad_banks
      $error("register map holds three slices per bank");
   end

   rd_kind_e               kind;
   logic [2:0]             gsel;
   logic [BUS_W-1:0]       status;
   logic [GROUP_W-1:0]     byte_sel;

   always_comb begin
      if (addr == OFS_STATUS)   kind = RD_STATUS;
      else if (addr == OFS_GAP) kind = RD_GAP;
      else                      kind = RD_LEVEL;
   end

   assign gsel = addr[2] ? (3'(BANK_GROUPS) + {1'b0, addr[1:0]}) : {1'b0, addr[1:0]};

   always_comb begin
      byte_sel = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (gsel == 3'(g)) byte_sel = lvl[g*GROUP_W +: GROUP_W];
      end
   end

   always_comb begin
      status           = '0;
      status[NUM_GROUPS-1:0] = flags;
      status[PEND_BIT] = ~|flags;
   end

   always_comb begin
      case (kind)
         RD_STATUS: rdata = status;
         RD_LEVEL:  rdata = byte_sel;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
   import cos_port_pkg::*;
#(
   parameter int GROUP_W     = 8,
   parameter int BANK_GROUPS = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_GROUPS = 2 * BANK_GROUPS,
   localparam int LINES      = GROUP_W * NUM_GROUPS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [47:0]      din,
   input  logic [2:0]       addr,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             irq
);
   if (LINES != 48) begin : g_bad_lines
      $error("port is built for 48 lines");
   end

   logic [LINES-1:0]      lvl;
   logic [NUM_GROUPS-1:0] arm;
   logic [NUM_GROUPS-1:0] flags;
   logic                  clr;

   cos_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(din), .q(lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            arm <= '0;
      else if (wr_en && addr == OFS_STATUS)  arm <= wdata[NUM_GROUPS-1:0];
   end

   assign clr = rd_en && (addr == OFS_STATUS);

   cos_group_detect #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .arm(arm), .clr(clr), .flags(flags)
   );

   cos_regmap #(.GROUP_W(GROUP_W), .BANK_GROUPS(BANK_GROUPS)) u_regmap (
      .addr(addr), .lvl(lvl), .flags(flags), .rdata(rdata)
   );

   assign irq = |flags;

   // R7, R10: the request line and the pending bit always disagree
   p_irq_vs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_STATUS) |-> (irq == !rdata[PEND_BIT]));
   // R3: the gap offset and the top status bit stay zero
   p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_GAP) |-> (rdata == 8'h00));
   p_status_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_STATUS) |-> !rdata[7]);
   // R4: writes elsewhere leave the arm bits alone
   p_arm_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == OFS_STATUS) |=> $stable(arm));
endmodule

// File: tb/cos_input_port_bench.sv
module cos_input_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] din = '0;
   logic [2:0]  addr = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   cos_input_port u_cos_input_port (
      .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rd_en(rd_en),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      addr = a; wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R10 irq after reset", {7'd0, irq}, 8'h00);
      bus_read(3'd7, v); check("R11 status after reset", v, 8'h40);
      bus_read(3'd3, v); check("R3 gap offset", v, 8'h00);
   endtask

   task automatic t_levels();
      logic [7:0] v;
      @(negedge clk) din = 48'h9A_3C_E1_0F_5A_81;
      settle();
      bus_read(3'd0, v); check("R1 byte0", v, 8'h81);
      bus_read(3'd1, v); check("R1 byte1", v, 8'h5A);
      bus_read(3'd2, v); check("R1 byte2", v, 8'h0F);
      bus_read(3'd4, v); check("R2 byte4", v, 8'hE1);
      bus_read(3'd5, v); check("R2 byte5", v, 8'h3C);
      bus_read(3'd6, v); check("R2 byte6", v, 8'h9A);
      bus_read(3'd3, v); check("R3 gap with levels", v, 8'h00);
   endtask

   task automatic t_unarmed();
      logic [7:0] v;
      bus_read(3'd7, v); check("R6 no flags while disarmed", v, 8'h40);
      @(negedge clk) din[17] = ~din[17];
      settle();
      check("R6 irq stays low", {7'd0, irq}, 8'h00);
      bus_write(3'd2, 8'h3F);
      @(negedge clk) din[3] = ~din[3];
      settle();
      bus_read(3'd7, v); check("R4 write to other offset ignored", v, 8'h40);
      bus_write(3'd7, 8'h04);
      settle();
      bus_read(3'd7, v); check("R6 change not remembered", v, 8'h40);
   endtask

   task automatic t_rise_fall();
      logic [7:0] v;
      bus_write(3'd7, 8'h3F);
      settle();
      @(negedge clk) din[9] = 1'b1;
      if (din[9] == 1'b1) din[9] = 1'b1;
      din[9] = ~u_cos_input_port_din_shadow(9);
      settle();
      check("R10 irq high with flag", {7'd0, irq}, 8'h01);
      bus_read(3'd7, v); check("R5 R7 slice1 flag", v, 8'h02);
      bus_read(3'd7, v); check("R8 cleared by read", v, 8'h40);
      check("R10 irq low after clear", {7'd0, irq}, 8'h00);
      @(negedge clk) din[45] = ~din[45];
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R5 not yet after two edges", {7'd0, irq}, 8'h00);
      @(negedge clk);
      check("R5 raised after third edge", {7'd0, irq}, 8'h01);
      bus_read(3'd7, v); check("R5 slice5 flag", v, 8'h20);
      @(negedge clk) begin din[1] = ~din[1]; din[36] = ~din[36]; end
      settle();
      bus_read(3'd7, v); check("R5 two slices", v, 8'h11);
   endtask

   function automatic logic u_cos_input_port_din_shadow(input int i);
      return din[i];
   endfunction

   task automatic t_collision();
      logic [7:0] v;
      @(negedge clk) din[0] = ~din[0];
      settle();
      @(negedge clk) din[20] = ~din[20];
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      addr = 3'd7; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk) rd_en = 1'b0;
      check("R9 read returns older flag", v, 8'h01);
      bus_read(3'd7, v); check("R9 collided change kept", v, 8'h04);
   endtask

   task automatic t_disarm_all();
      logic [7:0] v;
      bus_write(3'd7, 8'h00);
      @(negedge clk) din[12] = ~din[12];
      settle();
      bus_read(3'd7, v); check("R4 write of zero disarms", v, 8'h40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_levels();
      t_unarmed();
      t_rise_fall();
      t_collision();
      t_disarm_all();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule